// File: doc/BRIEF.md
# Variable-Length Instruction Parcel Aligner

This block sits between an instruction fetch stage and a decoder. Fetch hands it 16-bit parcels in program order, one per cycle, over a valid/ready handshake. Instructions may begin on any 16-bit boundary and may span several parcels. The aligner reads the low bits of the parcel at the head of its buffer, works out how many parcels the instruction occupies, and waits until all of them are held. It then presents the whole instruction on a 64-bit output with a two-bit length code, over a second valid/ready handshake.

Lengths of 16, 32, 48 and 64 bits are supported. A head parcel that announces a longer form, or the reserved length count, is not supported. In that case the block raises an error flag for one cycle, drops that single parcel and produces no output for it. A flush input, used when fetch is redirected, empties the buffer in one cycle and discards any instruction that was only partly gathered.

Top module: `pa_aligner`

## Requirements
- R1: After reset `outValid` and `errFlag` are low and `inReady` is high.
- R2: A head parcel whose bits [1:0] are not 11 is a complete 16-bit instruction, reported with `outLen` = 0.
- R3: A head parcel with bits [1:0] = 11 and bits [4:2] not 111 starts a 32-bit instruction, reported with `outLen` = 1.
- R4: A head parcel with bits [5:0] = 011111 starts a 48-bit instruction, reported with `outLen` = 2.
- R5: A head parcel with bits [6:0] = 0111111 starts a 64-bit instruction, reported with `outLen` = 3.
- R6: A head parcel with bits [6:0] = 1111111 (forms of 80 bits or more, including the reserved count) raises `errFlag` for one cycle without `outValid`. The parcel is consumed and nothing is emitted for it.
- R7: The first parcel of an instruction appears on `outInstr[15:0]`, each later parcel in the next 16 bits up, and every bit above the instruction length is zero.
- R8: `inReady` is high exactly when fewer than `DEPTH` (default 4) parcels are buffered and `flush` is low. Four parcels can be taken back to back while the output is stalled.
- R9: While `outValid` is high and `outReady` is low, the presented instruction and length stay unchanged.
- R10: A cycle with `flush` high shows neither `outValid`, `errFlag` nor `inReady`. After it the buffer is empty, and a partly gathered instruction never reaches the output.
- R11: Instructions of mixed lengths are packed back to back. Each new instruction starts with the parcel that follows the last parcel of the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all buffered parcels |
| inValid | input | 1 | Parcel offered |
| inReady | output | 1 | Parcel can be accepted |
| inParcel | input | 16 | Incoming parcel |
| outValid | output | 1 | Whole instruction available |
| outReady | input | 1 | Consumer takes the instruction |
| outInstr | output | 64 | Instruction, first parcel in the low bits, zero-filled above |
| outLen | output | 2 | Length code: 0=16, 1=32, 2=48, 3=64 bits |
| errFlag | output | 1 | Head parcel has an unsupported length and is being dropped |

## Verification
A long stream cycles through all four lengths, with first-parcel low bits drawn at random inside each class and unsupported parcels mixed in. This shows whether each decode rule picks the right parcel count, and whether the boundaries stay correct after odd-length instructions and dropped parcels. A stalled-output pattern fills the buffer with one 64-bit instruction, which separates correct back-pressure from overrun and checks that the held output does not change. A flush that lands mid-instruction and is followed by a short instruction catches stale parcels: if any survive, they would be glued onto the new instruction.

// File: rtl/pa_pkg.sv
package pa_pkg;

  localparam int PARCEL_W = 16;
  localparam int INSTR_W  = 64;

  typedef struct packed {
    logic       push;     // store inParcel at the tail
    logic [2:0] popNum;   // parcels removed from the head
    logic       clear;    // drop everything
    logic [2:0] keepNum;  // parcels shown on the output
  } paStrobes_t;

  typedef struct packed {
    logic       bad;
    logic [1:0] code;
  } paLen_t;

  function automatic paLen_t lenDecode(input logic [6:0] low);
    paLen_t r;
    r.bad  = 1'b0;
    r.code = 2'd0;
    if (low[1:0] != 2'b11)             r.code = 2'd0;
    else if (low[4:2] != 3'b111)       r.code = 2'd1;
    else if (low[5] == 1'b0)           r.code = 2'd2;
    else if (low[6] == 1'b0)           r.code = 2'd3;
    else                               r.bad  = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/pa_buffer.sv
module pa_buffer
  import pa_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int FW = DEPTH * PARCEL_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  paStrobes_t          strb,
  input  logic [PARCEL_W-1:0] inParcel,
  output logic [PARCEL_W-1:0] headParcel,
  output logic [CW-1:0]       cnt,
  output logic [INSTR_W-1:0]  instrOut
);

  logic [FW-1:0] bufQ, bufD, shifted, slotMask, slotData;
  logic [CW-1:0] cntQ, cntD, cntAfter;
  logic [INSTR_W-1:0] keepMask;

  always_comb begin
    shifted  = bufQ >> {strb.popNum, 4'b0000};
    cntAfter = cntQ - CW'(strb.popNum);
    slotMask = FW'({PARCEL_W{1'b1}}) << {cntAfter, 4'b0000};
    slotData = FW'(inParcel) << {cntAfter, 4'b0000};
    bufD     = shifted;
    cntD     = cntAfter;
    if (strb.push) begin
      bufD = (shifted & ~slotMask) | slotData;
      cntD = cntAfter + CW'(1);
    end
    if (strb.clear) begin
      bufD = '0;
      cntD = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufQ <= '0;
      cntQ <= '0;
    end else begin
      bufQ <= bufD;
      cntQ <= cntD;
    end
  end

  always_comb begin
    case (strb.keepNum)
      3'd1:    keepMask = 64'h0000_0000_0000_FFFF;
      3'd2:    keepMask = 64'h0000_0000_FFFF_FFFF;
      3'd3:    keepMask = 64'h0000_FFFF_FFFF_FFFF;
      3'd4:    keepMask = 64'hFFFF_FFFF_FFFF_FFFF;
      default: keepMask = '0;
    endcase
  end

  assign headParcel = bufQ[PARCEL_W-1:0];
  assign cnt        = cntQ;
  assign instrOut   = bufQ[INSTR_W-1:0] & keepMask;

endmodule

// File: rtl/pa_ctrl.sv
module pa_ctrl
  import pa_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                cnt_dummy_unused_n,
  input  logic [CW-1:0]       cnt,
  input  logic [PARCEL_W-1:0] headParcel,
  input  logic                flush,
  input  logic                inValid,
  input  logic                outReady,
  output paStrobes_t          strb,
  output logic                inReady,
  output logic                outValid,
  output logic [1:0]          outLen,
  output logic                errFlag
);

  paLen_t     dec;
  logic [2:0] need;
  logic       haveHead;
  logic       take;

  always_comb begin
    dec      = lenDecode(headParcel[6:0]);
    need     = {1'b0, dec.code} + 3'd1;
    haveHead = (cnt != '0) && !flush && cnt_dummy_unused_n;
    errFlag  = haveHead && dec.bad;
    outValid = haveHead && !dec.bad && (cnt >= CW'(need));
    inReady  = !flush && (cnt < CW'(DEPTH));
    take     = outValid && outReady;

    strb.push    = inValid && inReady;
    strb.clear   = flush;
    strb.popNum  = errFlag ? 3'd1 : (take ? need : 3'd0);
    strb.keepNum = outValid ? need : 3'd0;
  end

  assign outLen = dec.code;

endmodule

// File: rtl/pa_aligner.sv
module pa_aligner
  import pa_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        flush,
  input  logic        inValid,
  output logic        inReady,
  input  logic [15:0] inParcel,
  output logic        outValid,
  input  logic        outReady,
  output logic [63:0] outInstr,
  output logic [1:0]  outLen,
  output logic        errFlag
);

  localparam int CW = $clog2(DEPTH + 1);

  paStrobes_t          strb;
  logic [PARCEL_W-1:0] headParcel;
  logic [CW-1:0]       cnt;

  pa_buffer #(.DEPTH(DEPTH)) u_buf (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .inParcel   (inParcel),
    .headParcel (headParcel),
    .cnt        (cnt),
    .instrOut   (outInstr)
  );

  pa_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .cnt_dummy_unused_n (rstN),
    .cnt        (cnt),
    .headParcel (headParcel),
    .flush      (flush),
    .inValid    (inValid),
    .outReady   (outReady),
    .strb       (strb),
    .inReady    (inReady),
    .outValid   (outValid),
    .outLen     (outLen),
    .errFlag    (errFlag)
  );

endmodule

// File: rtl/pa_aligner_chk.sv
module pa_aligner_chk (
  input logic        clk,
  input logic        rstN,
  input logic        flush,
  input logic        inReady,
  input logic        outValid,
  input logic        outReady,
  input logic [63:0] outInstr,
  input logic [1:0]  outLen,
  input logic        errFlag
);

  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !outValid);  // R6

  AST_SHORT_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outInstr[1:0] != 2'b11) |-> (outLen == 2'd0));  // R2

  AST_WORD_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outInstr[1:0] == 2'b11 && outInstr[4:2] != 3'b111) |-> (outLen == 2'd1));  // R3

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLen == 2'd0) |-> (outInstr[63:16] == '0));  // R7

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !flush) |=> (flush || (outValid && $stable(outInstr) && $stable(outLen))));  // R9

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (!outValid && !errFlag));  // R10

  AST_FLUSH_NO_READY: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> (!inReady && !outValid));  // R8

endmodule

bind pa_aligner pa_aligner_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .flush    (flush),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outInstr (outInstr),
  .outLen   (outLen),
  .errFlag  (errFlag)
);

// File: tb/sim_pa_aligner.sv
module sim_pa_aligner;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [15:0] inParcel = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [63:0] outInstr;
  logic [1:0]  outLen;
  logic        errFlag;

  int numChecks = 0;
  int numFails  = 0;
  int cycles    = 0;
  logic [66:0] expQ[$];

  always #4 clk = ~clk;

  pa_aligner u0 (
    .clk(clk), .rstN(rstN), .flush(flush), .inValid(inValid), .inReady(inReady),
    .inParcel(inParcel), .outValid(outValid), .outReady(outReady),
    .outInstr(outInstr), .outLen(outLen), .errFlag(errFlag)
  );

  function automatic string lenTag(input logic [1:0] l);
    case (l)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    numChecks++;
    if (!ok) begin
      numFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", numChecks, numFails);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && !flush) begin
      if (errFlag) begin
        if (expQ.size() == 0) check(1'b0, "R6 unexpected error", 64'd1, 64'd0);
        else begin
          logic [66:0] e;
          e = expQ.pop_front();
          check(e[66] == 1'b1, "R6 error flag", {63'd0, errFlag}, {63'd0, e[66]});
        end
      end
      if (outValid && outReady) begin
        if (expQ.size() == 0) check(1'b0, "R11 unexpected instruction", outInstr, 64'd0);
        else begin
          logic [66:0] e;
          e = expQ.pop_front();
          check(e[66] == 1'b0 && e[65:64] == outLen, {lenTag(e[65:64]), " length code"},
                {62'd0, outLen}, {62'd0, e[65:64]});
          check(e[63:0] == outInstr, "R7 R11 instruction bits", outInstr, e[63:0]);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      numChecks++;
      numFails++;
      $display("FAIL watchdog actual=%0d expected<=50000", cycles);
      finishRun();
    end
  end

  task automatic pushParcel(input logic [15:0] p);
    @(negedge clk);
    inParcel = p;
    inValid  = 1'b1;
    #1;
    while (!inReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 inValid = 1'b0;
  endtask

  task automatic makeInstr(input int len, input logic [63:0] rnd, output logic [63:0] w);
    w = rnd;
    case (len)
      0: w[1:0] = (rnd[1:0] == 2'b11) ? 2'b01 : rnd[1:0];
      1: begin w[1:0] = 2'b11; if (w[4:2] == 3'b111) w[4:2] = 3'b010; end
      2: w[5:0] = 6'b011111;
      default: w[6:0] = 7'b0111111;
    endcase
    if (len < 3) w = w & ((64'd1 << (16 * (len + 1))) - 64'd1);
  endtask

  task automatic sendInstr(input int len, input logic [63:0] rnd);
    logic [63:0] w;
    makeInstr(len, rnd, w);
    expQ.push_back({1'b0, 2'(len), w});
    for (int p = 0; p <= len; p++) pushParcel(w[16*p +: 16]);
  endtask

  task automatic sendBad(input logic [15:0] rnd);
    logic [15:0] p;
    p = rnd;
    p[6:0] = 7'b1111111;
    expQ.push_back({1'b1, 66'd0});
    pushParcel(p);
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [63:0] w;
    logic [63:0] held;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(!outValid && !errFlag && inReady, "R1 reset state",
          {61'd0, outValid, errFlag, inReady}, 64'd1);

    // mixed stream with unsupported parcels interleaved
    @(posedge clk); #1 outReady = 1'b1;
    for (int k = 0; k < 60; k++) begin
      sendInstr((k * 7 + k / 4) % 4, {$urandom(), $urandom()});
      if (k % 9 == 4) sendBad(16'($urandom()));
      if (k % 13 == 6) sendBad(16'h7000 | 16'($urandom()));
    end
    drain();

    // back-pressure: one 64-bit instruction fills the buffer
    @(posedge clk); #1 outReady = 1'b0;
    makeInstr(3, 64'h1234_5678_9ABC_DEF0, w);
    expQ.push_back({1'b0, 2'd3, w});
    for (int p = 0; p < 4; p++) pushParcel(w[16*p +: 16]);
    @(negedge clk);
    check(!inReady, "R8 full buffer not ready", {63'd0, inReady}, 64'd0);
    check(outValid && outLen == 2'd3, "R5 stalled length", {62'd0, outLen}, 64'd3);
    held = outInstr;
    check(held == w, "R7 stalled data", held, w);
    repeat (3) @(negedge clk);
    check(outValid && outInstr == held, "R9 held while stalled", outInstr, held);
    @(posedge clk); #1 outReady = 1'b1;
    drain();

    // flush in the middle of a 64-bit instruction
    @(posedge clk); #1 outReady = 1'b0;
    makeInstr(3, 64'hAAAA_BBBB_CCCC_DDDD, w);
    pushParcel(w[15:0]);
    pushParcel(w[31:16]);
    @(negedge clk);
    check(!outValid, "R10 partial not shown", {63'd0, outValid}, 64'd0);
    @(posedge clk); #1 flush = 1'b1;
    @(negedge clk);
    check(!outValid && !inReady && !errFlag, "R10 flush cycle",
          {61'd0, outValid, inReady, errFlag}, 64'd0);
    @(posedge clk); #1 flush = 1'b0;
    @(negedge clk);
    check(!outValid && inReady, "R10 empty after flush", {62'd0, outValid, inReady}, 64'd1);
    @(posedge clk); #1 outReady = 1'b1;
    sendInstr(0, 64'h0000_0000_0000_4321);
    sendInstr(1, 64'h0000_0000_5555_0003);
    drain();

    check(expQ.size() == 0, "R11 all expected emitted", 64'(expQ.size()), 64'd0);
    finishRun();
  end

endmodule